// File: doc/BRIEF.md
# PLL Lock Supervisor with Retry

This block oversees a PLL after it has been reprogrammed. A one-cycle start request begins a supervision run. The block waits a fixed interval, then checks the PLL lock status. If the PLL is locked, the run ends successfully. If it is not locked, the block drives the PLL reset high for a short pulse, releases it, and waits the full interval again before the next check.

The number of checks in a run is bounded. When the last allowed check still sees no lock, the run ends with a failure flag. The block reports how many reset pulses it issued during the run. A nonzero count shows that lock was reached only after retries.

The lock status is a single active-high bit, where 1 means locked. It passes through a flop synchronizer before it is used. All intervals are cycle-count parameters: the wait interval (nominally 5 ms of clock cycles), the reset pulse width and the check limit.

Top module: `pll_lock_supervisor`

## Requirements
- R1: After reset, `pll_rst_o`, `done_o` and `fail_o` are 0 and `retries_o` is 0.
- R2: An accepted start clears `done_o`, `fail_o` and `retries_o` on the next edge. The first check then falls WAIT_CYCLES edges after the start edge. Each later check falls WAIT_CYCLES edges after the reset pulse ends. So a run that locks after N pulses raises `done_o` on edge start+WAIT_CYCLES+N*(PULSE_CYCLES+WAIT_CYCLES).
- R3: A run makes at most MAX_CHECKS checks. If the last check finds no lock, `done_o` and `fail_o` both rise on edge start+MAX_CHECKS*WAIT_CYCLES+(MAX_CHECKS-1)*PULSE_CYCLES, with `retries_o` = MAX_CHECKS-1. No reset pulse follows that last check.
- R4: Every check that finds no lock, except the last allowed one, is followed at once by exactly one `pll_rst_o` pulse that is high for exactly PULSE_CYCLES cycles.
- R5: `retries_o` equals the number of reset pulses issued in the current run.
- R6: A check that finds lock ends the run at once. `done_o` rises with `fail_o` at 0, and no further reset pulse is issued.
- R7: `done_o`, `fail_o` and `retries_o` keep their final values until the next accepted start.
- R8: A start request while a run is in progress is ignored. It changes neither the timing nor the result of that run.
- R9: `lock_i` passes through SYNC_STAGES flops. With SYNC_STAGES=2, a check on edge E sees the level `lock_i` held just before edge E-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on the clock edge |
| lock_i | input | 1 | PLL lock status, asynchronous, 1 = locked |
| pll_rst_o | output | 1 | Reset to the PLL, active high |
| done_o | output | 1 | Run finished (success or failure) |
| fail_o | output | 1 | Run finished without lock |
| retries_o | output | $clog2(MAX_CHECKS) | Reset pulses issued in this run |

## Verification
Each result is due on a fixed edge counted from the start edge, and the bench predicts that edge from the R2 and R3 formulas. It samples on falling edges and counts rising edges from the start edge onward, so the measured edge of `done_o` can be compared directly with the formula. A behavioural PLL stub locks after a chosen number of reset pulses; the bench sweeps that number from 0 to beyond the check limit. For R9, the bench raises lock two and three edges before the first check, which shows where the synchronizer boundary falls.

// File: rtl/pls_pkg.sv
package pls_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_PULSE = 2'd2
   } pls_state_t;
endpackage

// File: rtl/pls_sync.sv
module pls_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pls_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pls_interval.sv
module pls_interval #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic hit_o
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("pls_interval: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          cnt <= '0;
      else if (!run_i)     cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;

   assign hit_o = run_i && (cnt == LAST);

   a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> cnt == '0);
endmodule

// File: rtl/pls_ctrl.sv
module pls_ctrl
   import pls_pkg::*;
#(
   parameter int MAX_CHECKS = 10,
   parameter int RW         = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          lock_s_i,
   input  logic          wait_hit_i,
   input  logic          pulse_hit_i,
   output logic          wait_run_o,
   output logic          pulse_run_o,
   output logic          done_o,
   output logic          fail_o,
   output logic [RW-1:0] retries_o
);
   localparam logic [RW-1:0] LAST_CHECK = RW'(MAX_CHECKS - 1);

   pls_state_t    state, state_nx;
   logic [RW-1:0] checks;
   logic          give_up;

   assign give_up = (checks == LAST_CHECK);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (start_i) state_nx = ST_WAIT;
         ST_WAIT:  if (wait_hit_i) begin
                      if (lock_s_i || give_up) state_nx = ST_IDLE;
                      else                     state_nx = ST_PULSE;
                   end
         ST_PULSE: if (pulse_hit_i) state_nx = ST_WAIT;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         checks    <= '0;
         retries_o <= '0;
         done_o    <= 1'b0;
         fail_o    <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == ST_IDLE && start_i) begin
            checks    <= '0;
            retries_o <= '0;
            done_o    <= 1'b0;
            fail_o    <= 1'b0;
         end else if (state == ST_WAIT && wait_hit_i) begin
            if (lock_s_i) begin
               done_o <= 1'b1;
            end else if (give_up) begin
               done_o <= 1'b1;
               fail_o <= 1'b1;
            end else begin
               checks    <= checks + 1'b1;
               retries_o <= retries_o + 1'b1;
            end
         end
      end
   end

   assign wait_run_o  = (state == ST_WAIT);
   assign pulse_run_o = (state == ST_PULSE);

   a_r3_retries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      retries_o <= LAST_CHECK);
   a_r3_fail_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> done_o);
   a_r5_count_per_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_run_o) |-> retries_o == $past(retries_o) + 1'b1);
   a_r4_pulse_after_check: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_run_o) |-> $past(wait_hit_i) && !$past(lock_s_i));
   a_r6_no_pulse_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !pulse_run_o && !wait_run_o);
   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start_i) |=> !done_o && !fail_o && retries_o == '0);
   a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && start_i && !wait_hit_i) |=> !done_o);
   a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !start_i) |=> $stable(done_o) && $stable(fail_o) && $stable(retries_o));
endmodule

// File: rtl/pll_lock_supervisor.sv
module pll_lock_supervisor #(
   parameter int WAIT_CYCLES  = 500000,
   parameter int PULSE_CYCLES = 4,
   parameter int MAX_CHECKS   = 10,
   parameter int SYNC_STAGES  = 2,
   localparam int RW          = $clog2(MAX_CHECKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          lock_i,
   output logic          pll_rst_o,
   output logic          done_o,
   output logic          fail_o,
   output logic [RW-1:0] retries_o
);
   logic lock_s, wait_run, wait_hit, pulse_run, pulse_hit;

   generate
      if (MAX_CHECKS < 2) begin : g_bad_checks
         $error("pll_lock_supervisor: MAX_CHECKS must be at least 2");
      end
      if (WAIT_CYCLES <= SYNC_STAGES) begin : g_bad_wait
         $error("pll_lock_supervisor: WAIT_CYCLES must exceed SYNC_STAGES");
      end
   endgenerate

   pls_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(lock_i), .q_o(lock_s));

   pls_interval #(.LIMIT(WAIT_CYCLES)) u_wait (
      .clk(clk), .rst_n(rst_n), .run_i(wait_run), .hit_o(wait_hit));

   pls_interval #(.LIMIT(PULSE_CYCLES)) u_pulse (
      .clk(clk), .rst_n(rst_n), .run_i(pulse_run), .hit_o(pulse_hit));

   pls_ctrl #(.MAX_CHECKS(MAX_CHECKS), .RW(RW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .lock_s_i(lock_s),
      .wait_hit_i(wait_hit), .pulse_hit_i(pulse_hit),
      .wait_run_o(wait_run), .pulse_run_o(pulse_run),
      .done_o(done_o), .fail_o(fail_o), .retries_o(retries_o));

   assign pll_rst_o = pulse_run;

   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !pll_rst_o && !done_o);
   a_r4_rst_not_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      pll_rst_o |-> !done_o);
endmodule

// File: tb/pll_lock_supervisor_bench.sv
module pll_lock_supervisor_bench;
   localparam int W  = 6;
   localparam int P  = 2;
   localparam int M  = 10;
   localparam int RW = $clog2(M);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic lock_i;
   logic pll_rst, done, fail;
   logic [RW-1:0] retries;

   int n_tests = 0;
   int n_fail  = 0;
   int target  = 0;
   int pulses  = 0;
   logic clr_pulses = 1'b0;
   logic prev_rst   = 1'b0;
   logic force_en   = 1'b0;
   logic force_val  = 1'b0;
   int   width      = 0;

   always #5 clk = ~clk;

   pll_lock_supervisor #(.WAIT_CYCLES(W), .PULSE_CYCLES(P), .MAX_CHECKS(M), .SYNC_STAGES(2))
      u_pll_lock_supervisor (
         .clk(clk), .rst_n(rst_n), .start_i(start), .lock_i(lock_i),
         .pll_rst_o(pll_rst), .done_o(done), .fail_o(fail), .retries_o(retries));

   // behavioural PLL: locks once target reset pulses have been seen
   always @(posedge clk) begin
      if (clr_pulses) pulses <= 0;
      else if (pll_rst && !prev_rst) pulses <= pulses + 1;
      prev_rst <= pll_rst;
   end
   assign lock_i = force_en ? force_val : ((pulses >= target) && !pll_rst);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // R4: each pulse width
   always @(negedge clk) begin
      if (pll_rst) width <= width + 1;
      else if (width != 0) begin
         chk(width == P, "R4 pulse width", width, P);
         width <= 0;
      end
   end

   // run one supervision; returns edges from start edge (inclusive) to done
   task automatic run(input int n, input bit poke_busy, output int lat);
      @(negedge clk);
      target = n;
      clr_pulses = 1'b1;
      @(negedge clk);
      clr_pulses = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 2000) begin
         @(negedge clk);
         lat++;
         if (poke_busy && (lat == 3 || lat == W + 2)) start = 1'b1;
         else start = 1'b0;
      end
      start = 1'b0;
   endtask

   initial begin
      int lat, exp_lat, exp_ret;
      bit exp_fail;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!pll_rst && !done && !fail && retries == 0, "R1 reset outputs",
          {pll_rst, done, fail}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!pll_rst && !done && !fail && retries == 0, "R1 idle after reset",
          {pll_rst, done, fail}, 0);

      // sweep lock-after-N-pulses: R2 R3 R4 R5 R6 R7
      for (int n = 0; n <= M + 1; n++) begin
         exp_fail = (n >= M);
         exp_ret  = exp_fail ? M - 1 : n;
         exp_lat  = exp_fail ? M * W + (M - 1) * P + 1 : W + 1 + n * (P + W);
         run(n, 1'b0, lat);
         chk(lat == exp_lat, exp_fail ? "R3 fail latency" : "R2 done latency", lat, exp_lat);
         chk(fail == exp_fail, exp_fail ? "R3 fail flag" : "R6 success flag", fail, exp_fail);
         chk(retries == exp_ret, "R5 retries count", retries, exp_ret);
         chk(pulses == exp_ret, "R4 pulses issued", pulses, exp_ret);
         repeat (2 * W + P) @(negedge clk);
         chk(pulses == exp_ret && !pll_rst, "R6 no pulse after end", pulses, exp_ret);
         chk(done && fail == exp_fail && retries == exp_ret, "R7 result held",
             retries, exp_ret);
      end

      // R8: start while busy
      run(3, 1'b1, lat);
      chk(lat == W + 1 + 3 * (P + W), "R8 busy start latency", lat, W + 1 + 3 * (P + W));
      chk(retries == 3 && !fail, "R8 busy start result", retries, 3);

      // R9: synchronizer boundary (lock raised 3 vs 2 edges before first check)
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         target = 1000;
         force_en = 1'b1;
         force_val = 1'b0;
         @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         lat = 1;
         while (!done && lat < 2000) begin
            if (lat == (k == 0 ? W - 2 : W - 1)) force_val = 1'b1;
            @(negedge clk);
            lat++;
         end
         chk(retries == k, "R9 sync boundary retries", retries, k);
         chk(!fail, "R9 sync boundary fail", fail, 0);
         force_en = 1'b0;
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule